// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

This block is one 16-bit timer channel that divides its clock. Each rising edge of `clk` is one input clock of the channel. A write strobe loads a divisor together with a 3-bit waveform code and a flag that picks plain binary or four-digit decimal (BCD) counting. The output pin then follows one of three waveforms:
- a terminal-count flag,
- a one-clock low pulse once per period,
- a square wave.

The gate input pauses counting. In the two periodic waveforms the gate also holds the output high, and a rising gate restarts the period.

The present counter value is always driven on `cnt_val`. A divisor of zero stands for the largest count the numbering allows. Software reads the count straight from that port and rewrites the channel at any time with a new load.

Top module: `divtimer_chan`

## Requirements
- R1: After reset `out_pin` is 1 and `cnt_val` is 0, and neither changes on any clock until the first load.
- R2: On the edge that samples `ld_stb` high, the divisor, waveform code and numbering take effect, and `cnt_val` starts the new sequence on that same edge. A load while the channel is running abandons the old sequence.
- R3: Terminal-count waveform. `out_pin` is 0 from the load edge on. It turns 1 on the N-th enabled edge, when the count reaches zero, and stays 1 until the next load. The count keeps decrementing and wraps past zero.
- R4: Rate waveform. For a divisor N of at least 2, `cnt_val` runs N, N-1, ..., 1 and then reloads N, so the period is N clocks. `out_pin` is 0 exactly while the count is 1.
- R5: Square waveform. For a divisor N of at least 2, `out_pin` is 1 for ceil(N/2) clocks and then 0 for floor(N/2) clocks. The counter is loaded with the length of each half and counts that half down to 1, so `cnt_val` shows the clocks left in the current half.
- R6: A loaded divisor of 0 acts as 65536 in binary numbering and as 10000 in BCD numbering.
- R7: In BCD numbering each nibble of `cnt_val` is one decimal digit, least significant in bits 3:0. A decrement borrows digit by digit, so 0100 becomes 0099 and 0000 becomes 9999.
- R8: While `gate` is sampled low, `cnt_val` holds its value in every waveform. In the terminal-count waveform, raising `gate` again resumes counting from that value.
- R9: In the rate and square waveforms, a low `gate` drives `out_pin` to 1 on the next edge. The first edge that samples `gate` high again reloads the counter and restarts the period with `out_pin` at 1.
- R10: `ld_mode` codes 2 and 6 select the rate waveform, codes 3 and 7 select the square waveform, and every other code selects the terminal-count waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock; every enabled rising edge is one count step |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_stb | input | 1 | Load strobe for divisor, waveform code and numbering |
| ld_div | input | 16 | Divisor; BCD digits when `ld_bcd` is 1, 0 means maximum |
| ld_mode | input | 3 | Waveform code (see R10) |
| ld_bcd | input | 1 | 1 selects four-digit BCD numbering, 0 selects binary |
| gate | input | 1 | Count enable; also restarts the periodic waveforms |
| out_pin | output | 1 | Waveform output |
| cnt_val | output | 16 | Present counter value |

## Verification
The zero divisor is run through a whole period in both numberings. A design that treats zero as zero stalls or fires at once. A design that uses the binary maximum in BCD gets the wrong period length. BCD borrows across more than one digit (0100 to 0099, 0000 to 9999) are checked at the count port, where a plain binary decrement would show 00FF or FFFF. Odd square-wave divisors check that the extra clock falls in the high half. Gate drops in each waveform check two things: that the count freezes without reloading in the terminal-count waveform, and that a rising gate restarts the period in the periodic ones. Getting either wrong shifts every later edge of the output.

// File: rtl/divtimer_pkg.sv
package divtimer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DIGITS = CNT_W / 4;
  localparam int unsigned EFF_W  = CNT_W + 1;

  localparam logic [EFF_W-1:0] MAX_BIN = EFF_W'(1) << CNT_W;
  localparam logic [EFF_W-1:0] MAX_BCD = EFF_W'(10 ** DIGITS);

  typedef enum logic [1:0] {
    WAVE_TERM   = 2'd0,
    WAVE_RATE   = 2'd1,
    WAVE_SQUARE = 2'd2
  } wave_e;

  // codes with low bits 2'b10 / 2'b11 and bit 2 don't-care pick the periodic waveforms
  function automatic wave_e decode_wave(input logic [2:0] code);
    case (code)
      3'd2, 3'd6: return WAVE_RATE;
      3'd3, 3'd7: return WAVE_SQUARE;
      default:    return WAVE_TERM;
    endcase
  endfunction

  // one decimal step down, borrowing across nibbles
  function automatic logic [CNT_W-1:0] bcd_minus_one(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic             borrow;
    r      = v;
    borrow = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (v[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
        else begin
          r[4*d +: 4] = v[4*d +: 4] - 4'd1;
          borrow      = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [EFF_W-1:0] bcd_to_bin(input logic [CNT_W-1:0] v);
    logic [EFF_W-1:0] acc;
    acc = '0;
    for (int d = DIGITS - 1; d >= 0; d--)
      acc = acc * EFF_W'(10) + EFF_W'(v[4*d +: 4]);
    return acc;
  endfunction

  function automatic logic [CNT_W-1:0] bin_to_bcd(input logic [EFF_W-1:0] b);
    logic [EFF_W-1:0] rest;
    logic [CNT_W-1:0] r;
    rest = b;
    r    = '0;
    for (int d = 0; d < DIGITS; d++) begin
      r[4*d +: 4] = 4'(rest % EFF_W'(10));
      rest        = rest / EFF_W'(10);
    end
    return r;
  endfunction
endpackage

// File: rtl/dt_decrement.sv
module dt_decrement
  import divtimer_pkg::*;
(
  input  logic [CNT_W-1:0] cur,
  input  logic             use_bcd,
  output logic [CNT_W-1:0] nxt
);
  always_comb begin
    if (use_bcd) nxt = bcd_minus_one(cur);
    else         nxt = cur - CNT_W'(1);
  end
endmodule

// File: rtl/dt_reload_calc.sv
module dt_reload_calc
  import divtimer_pkg::*;
(
  input  logic [CNT_W-1:0] divisor,
  input  logic             use_bcd,
  output logic [CNT_W-1:0] full_val,
  output logic [CNT_W-1:0] hi_val,
  output logic [CNT_W-1:0] lo_val
);
  logic [EFF_W-1:0] n_eff;
  logic [EFF_W-1:0] hi_b;
  logic [EFF_W-1:0] lo_b;

  always_comb begin
    if (divisor == '0)  n_eff = use_bcd ? MAX_BCD : MAX_BIN;
    else if (use_bcd)   n_eff = bcd_to_bin(divisor);
    else                n_eff = EFF_W'(divisor);
    hi_b     = (n_eff + EFF_W'(1)) >> 1;
    lo_b     = n_eff >> 1;
    full_val = divisor;
    hi_val   = use_bcd ? bin_to_bcd(hi_b) : hi_b[CNT_W-1:0];
    lo_val   = use_bcd ? bin_to_bcd(lo_b) : lo_b[CNT_W-1:0];
  end
endmodule

// File: rtl/dt_wave.sv
module dt_wave
  import divtimer_pkg::*;
(
  input  wave_e            wave,
  input  logic             gate,
  input  logic             gate_rise,
  input  logic             out_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] dec_val,
  input  logic [CNT_W-1:0] full_val,
  input  logic [CNT_W-1:0] hi_val,
  input  logic [CNT_W-1:0] lo_val,
  output logic [CNT_W-1:0] cnt_d,
  output logic             out_d,
  output logic             ev_term,
  output logic             ev_wrap,
  output logic             ev_flip,
  output logic             ev_restart
);
  logic at_one;
  assign at_one = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d      = cnt_q;
    out_d      = out_q;
    ev_term    = 1'b0;
    ev_wrap    = 1'b0;
    ev_flip    = 1'b0;
    ev_restart = 1'b0;
    case (wave)
      WAVE_RATE: begin
        if (!gate) out_d = 1'b1;
        else if (gate_rise || at_one) begin
          cnt_d      = full_val;
          out_d      = 1'b1;
          ev_restart = gate_rise;
          ev_wrap    = !gate_rise;
        end else begin
          cnt_d = dec_val;
          out_d = (dec_val != CNT_W'(1));
        end
      end
      WAVE_SQUARE: begin
        if (!gate) out_d = 1'b1;
        else if (gate_rise) begin
          cnt_d      = hi_val;
          out_d      = 1'b1;
          ev_restart = 1'b1;
        end else if (at_one) begin
          cnt_d   = out_q ? lo_val : hi_val;
          out_d   = !out_q;
          ev_flip = 1'b1;
        end else begin
          cnt_d = dec_val;
        end
      end
      default: begin
        if (gate) begin
          cnt_d   = dec_val;
          ev_term = (dec_val == '0);
          if (ev_term) out_d = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/divtimer_chan.sv
module divtimer_chan
  import divtimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic [CNT_W-1:0] ld_div,
  input  logic [2:0]       ld_mode,
  input  logic             ld_bcd,
  input  logic             gate,
  output logic             out_pin,
  output logic [CNT_W-1:0] cnt_val
);
  wave_e            wave_q;
  wave_e            ld_wave;
  logic             bcd_q;
  logic             armed_q;
  logic             gate_q;
  logic             out_q;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  logic [CNT_W-1:0] calc_div;
  logic             calc_bcd;
  logic [CNT_W-1:0] full_val, hi_val, lo_val, dec_val, cnt_d;
  logic             out_d, gate_rise;
  logic             ev_term, ev_wrap, ev_flip, ev_restart;

  assign ld_wave   = decode_wave(ld_mode);
  assign gate_rise = gate && !gate_q;
  assign calc_div  = ld_stb ? ld_div : div_q;
  assign calc_bcd  = ld_stb ? ld_bcd : bcd_q;

  dt_reload_calc u_reload (
    .divisor (calc_div),
    .use_bcd (calc_bcd),
    .full_val(full_val),
    .hi_val  (hi_val),
    .lo_val  (lo_val)
  );

  dt_decrement u_dec (
    .cur    (cnt_q),
    .use_bcd(bcd_q),
    .nxt    (dec_val)
  );

  dt_wave u_wave (
    .wave      (wave_q),
    .gate      (gate),
    .gate_rise (gate_rise),
    .out_q     (out_q),
    .cnt_q     (cnt_q),
    .dec_val   (dec_val),
    .full_val  (full_val),
    .hi_val    (hi_val),
    .lo_val    (lo_val),
    .cnt_d     (cnt_d),
    .out_d     (out_d),
    .ev_term   (ev_term),
    .ev_wrap   (ev_wrap),
    .ev_flip   (ev_flip),
    .ev_restart(ev_restart)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q  <= WAVE_TERM;
      bcd_q   <= 1'b0;
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
      out_q   <= 1'b1;
      div_q   <= '0;
      cnt_q   <= '0;
    end else begin
      gate_q <= gate;
      if (ld_stb) begin
        wave_q  <= ld_wave;
        bcd_q   <= ld_bcd;
        div_q   <= ld_div;
        armed_q <= 1'b1;
        cnt_q   <= (ld_wave == WAVE_SQUARE) ? hi_val : ld_div;
        out_q   <= (ld_wave != WAVE_TERM);
      end else if (armed_q) begin
        cnt_q <= cnt_d;
        out_q <= out_d;
      end
    end
  end

  assign out_pin = out_q;
  assign cnt_val = cnt_q;

  // R1: idle channel keeps its reset values
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (cnt_q == '0) && out_q);

  // R3: output drops at a terminal-count load
  a_r3_low_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && ld_wave == WAVE_TERM) |=> !out_pin);

  // R3: once high, terminal flag holds until a load
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && armed_q && wave_q == WAVE_TERM && out_q) |=> out_q);

  // R3: terminal event raises the output
  a_r3_term_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && armed_q && ev_term) |=> out_q && (cnt_q == '0));

  // R4: rate pulse lasts exactly one clock
  a_r4_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && armed_q && wave_q == WAVE_RATE && !out_q) |=> out_q);

  // R4: wrap reloads the stored divisor
  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && armed_q && ev_wrap) |=> (cnt_q == div_q));

  // R5: square output toggles when a half ends
  a_r5_half_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && armed_q && ev_flip) |=> (out_q != $past(out_q)));

  // R8: low gate freezes the count
  a_r8_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && !gate) |=> $stable(cnt_q));

  // R9: low gate forces periodic output high
  a_r9_gate_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && armed_q && wave_q != WAVE_TERM && !gate) |=> out_q);

  // R9: rising gate restarts with output high
  a_r9_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && armed_q && ev_restart) |=> out_q);
endmodule

// File: tb/divtimer_chan_tb.sv
module divtimer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_stb = 1'b0;
  logic [15:0] ld_div = '0;
  logic [2:0]  ld_mode = '0;
  logic        ld_bcd = 1'b0;
  logic        gate = 1'b1;
  logic        out_pin;
  logic [15:0] cnt_val;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  divtimer_chan u_dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_div(ld_div),
    .ld_mode(ld_mode), .ld_bcd(ld_bcd), .gate(gate),
    .out_pin(out_pin), .cnt_val(cnt_val)
  );

  // 0 terminal, 1 rate, 2 square (R10)
  function automatic int kind_of(int unsigned code);
    if (code == 2 || code == 6) return 1;
    if (code == 3 || code == 7) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] enc(bit b, int unsigned v);
    logic [15:0] r;
    int unsigned x;
    if (!b) return 16'(v);
    x = v;
    r = '0;
    for (int d = 0; d < 4; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int unsigned modulus(bit b);
    return b ? 10000 : 65536;
  endfunction

  function automatic bit exp_out(int kind, int unsigned n, int unsigned k);
    case (kind)
      1:       return (k % n) != (n - 1);
      2:       return (k % n) < ((n + 1) / 2);
      default: return k >= n;
    endcase
  endfunction

  function automatic int unsigned exp_cnt(int kind, bit b, int unsigned n, int unsigned k);
    int unsigned m, p, hi;
    m = modulus(b);
    case (kind)
      1: return (n - (k % n)) % m;
      2: begin
        p  = k % n;
        hi = (n + 1) / 2;
        return (p < hi) ? (hi - p) : ((n / 2) - (p - hi));
      end
      default: return ((n % m) + m - (k % m)) % m;
    endcase
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load(int unsigned code, bit b, int unsigned nv);
    ld_stb  = 1'b1;
    ld_mode = 3'(code);
    ld_bcd  = b;
    ld_div  = enc(b, nv);
    step();
    ld_stb  = 1'b0;
  endtask

  task automatic follow(int kind, bit b, int unsigned n, int unsigned k0, int unsigned k1, string req);
    for (int unsigned k = k0; k <= k1; k++) begin
      chk({req, " out"}, out_pin, exp_out(kind, n, k));
      chk({req, " cnt"}, cnt_val, enc(b, exp_cnt(kind, b, n, k)));
      if (k != k1) step();
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) step();
    rst_n = 1'b1;
    // R1: reset state and no counting before a load
    chk("R1 out", out_pin, 1);
    chk("R1 cnt", cnt_val, 0);
    repeat (4) step();
    chk("R1 idle cnt", cnt_val, 0);
    chk("R1 idle out", out_pin, 1);

    // R3: terminal count with wrap past zero
    load(0, 0, 5);
    follow(0, 0, 5, 0, 8, "R3");

    // R7: BCD borrow chain 0100 -> 0099 and 0000 -> 9999
    load(0, 1, 100);
    follow(0, 1, 100, 0, 3, "R7");
    load(0, 1, 0);
    chk("R7 zero cnt", cnt_val, 16'h0000);
    step();
    chk("R7 wrap cnt", cnt_val, 16'h9999);

    // R6: zero divisor in BCD rate waveform -> 10000 clocks
    load(2, 1, 0);
    repeat (9998) step();
    follow(1, 1, 10000, 9998, 10001, "R6 bcd");

    // R6: zero divisor in binary terminal waveform -> 65536 clocks
    load(0, 0, 0);
    repeat (65534) step();
    follow(0, 0, 65536, 65534, 65537, "R6 bin");

    // R5: odd square divisors
    load(3, 0, 7);
    follow(2, 0, 7, 0, 15, "R5");
    load(3, 1, 9);
    follow(2, 1, 9, 0, 19, "R5 bcd");

    // R2: reload mid-run restarts with new waveform
    load(2, 0, 7);
    repeat (3) step();
    load(3, 0, 4);
    follow(2, 0, 4, 0, 9, "R2");

    // R8: terminal waveform freezes and resumes without reload
    load(0, 0, 10);
    repeat (3) step();
    gate = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R8 frozen cnt", cnt_val, 7);
      chk("R8 out low", out_pin, 0);
    end
    gate = 1'b1;
    step();
    chk("R8 resume cnt", cnt_val, 6);

    // R9: rate waveform gate handling
    load(2, 0, 6);
    repeat (5) step();
    chk("R4 pulse", out_pin, 0);
    chk("R4 cnt one", cnt_val, 1);
    gate = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9 forced high", out_pin, 1);
      chk("R8 rate frozen", cnt_val, 1);
    end
    gate = 1'b1;
    step();
    follow(1, 0, 6, 0, 13, "R9 restart");

    // R9: square waveform gate handling
    load(3, 0, 5);
    repeat (3) step();
    chk("R5 low half", out_pin, 0);
    gate = 1'b0;
    step();
    chk("R9 sq high", out_pin, 1);
    chk("R8 sq frozen", cnt_val, 2);
    gate = 1'b1;
    step();
    follow(2, 0, 5, 0, 10, "R9 sq restart");

    // R10 with R3/R4/R5: random codes, numbering and divisors
    for (int it = 0; it < 24; it++) begin
      int unsigned code, nv, kd;
      bit          b;
      code = $urandom % 8;
      b    = 1'($urandom % 2);
      nv   = 2 + ($urandom % 150);
      kd   = kind_of(code);
      load(code, b, nv);
      follow(kd, b, nv, 0, 2 * nv + 2, $sformatf("R10 code%0d", code));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule